// File: doc/BRIEF.md
# Per-CPU Interrupt Pending Selector with Fast-Interrupt Steering

This block is the arbitration stage of a multi-CPU interrupt distributor. For every CPU interface it looks across all interrupt sources. A source is a candidate for a CPU when it is pending, it is enabled, and its target mask names that CPU. Among the candidates it picks the most urgent one. A smaller priority number is more urgent. When two candidates have the same priority, the lower interrupt ID wins.

The winner is then gated twice, each time with a strict less-than test. The first test is against the CPU's priority mask. A winner that passes is reported as that CPU's current pending ID; otherwise the spurious ID 1023 is reported. The second test is against the CPU's running priority. A winner that also passes raises an interrupt line. On revision 2 or later, when the global fast-interrupt enable is set, a group-0 winner raises the FIQ line instead of the IRQ line. All outputs are computed from the input state and registered once per clock. Acknowledge, end-of-interrupt handling and register access belong to neighbouring blocks.

Top module: `pendsel_top`

## Requirements
- R1: While `rstN` is low, and immediately after it falls, every `irqOut` and `fiqOut` bit is 0 and every `curPendId` field is 1023.
- R2: Source i is a candidate for CPU c only if `pendVec[i]`, `enVec[i]` and `tgtVec[i*NUM_CPU+c]` are all 1. With no candidate, the CPU's ID is 1023 and both of its lines are low.
- R3: Among the candidates, the one with the smallest priority value (`prioVec[i*PRIO_W +: PRIO_W]`) wins.
- R4: The winner's ID is reported in `curPendId[c*10 +: 10]` only when its priority is strictly less than `prioMask[c*(PRIO_W+1) +: PRIO_W+1]`. Otherwise the ID is 1023 and no line is raised.
- R5: A line is raised for CPU c only when the winner's priority is also strictly less than `runPrio[c*(PRIO_W+1) +: PRIO_W+1]`. The reported ID does not depend on this test.
- R6: When `distGrp0En` is 0 or `cpuEn[c]` is 0, CPU c has both lines low and ID 1023.
- R7: When `revision` >= 2 and `fiqSigEn` is 1, a raised line whose winner has `grpVec` bit 0 (group 0) appears on `fiqOut[c]`, and `irqOut[c]` is 0.
- R8: A raised line for a group-1 winner (`grpVec` bit 1), or for any winner while `fiqSigEn` is 0, appears on `irqOut[c]`, and `fiqOut[c]` is 0.
- R9: When `revision` < 2, `fiqOut` stays 0 and raised lines go to `irqOut`.
- R10: Each CPU's ID and lines depend only on its own target bits, enable, mask and running priority.
- R11: Outputs take on the result of the inputs present at a rising clock edge, and hold it until the next rising edge.
- R12: When several candidates share the lowest priority value, the lowest interrupt ID wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pendVec | input | NUM_IRQ | Pending bit per source |
| enVec | input | NUM_IRQ | Enable bit per source |
| grpVec | input | NUM_IRQ | Group per source: 0 = group 0, 1 = group 1 |
| tgtVec | input | NUM_IRQ*NUM_CPU | Target bit, index i*NUM_CPU+c |
| prioVec | input | NUM_IRQ*PRIO_W | Priority per source; smaller is more urgent |
| distGrp0En | input | 1 | Global distribution enable for group 0 |
| fiqSigEn | input | 1 | Global enable for steering group 0 to FIQ |
| revision | input | REV_W | Architecture revision; steering needs >= 2 |
| cpuEn | input | NUM_CPU | Per-CPU interface enable |
| prioMask | input | NUM_CPU*(PRIO_W+1) | Per-CPU priority mask; 2^PRIO_W opens it fully |
| runPrio | input | NUM_CPU*(PRIO_W+1) | Per-CPU running priority; 2^PRIO_W means idle |
| irqOut | output | NUM_CPU | Normal interrupt line per CPU |
| fiqOut | output | NUM_CPU | Fast interrupt line per CPU |
| curPendId | output | NUM_CPU*10 | Current pending ID per CPU; 1023 when none |

## Verification
The assertions assume that every input is stable around the rising clock edge, so that a value seen at one edge is the value the registers captured. They also assume a mask or running priority of zero means that nothing can pass. The bench changes inputs only on falling edges. It uses masks and running priorities between 0 and 2^PRIO_W, and holds each stimulus for a full cycle before sampling. It then compares the results with a table of hand-derived values, including ties, boundary-equal priorities and revision changes.

// File: rtl/pendsel_pkg.sv
package pendsel_pkg;
  localparam int ID_W = 10;
  localparam logic [ID_W-1:0] SPURIOUS_ID = 10'd1023;
  localparam int FIQ_MIN_REV = 2;

  typedef struct packed {
    logic latchId;
    logic driveIrq;
    logic driveFiq;
  } pend_strobe_t;
endpackage

// File: rtl/pendsel_datapath.sv
module pendsel_datapath
  import pendsel_pkg::*;
#(
  parameter int NUM_IRQ = 64,
  parameter int NUM_CPU = 2,
  parameter int PRIO_W  = 8
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [NUM_IRQ-1:0]          pendVec,
  input  logic [NUM_IRQ-1:0]          enVec,
  input  logic [NUM_IRQ-1:0]          grpVec,
  input  logic [NUM_IRQ*NUM_CPU-1:0]  tgtVec,
  input  logic [NUM_IRQ*PRIO_W-1:0]   prioVec,
  input  pend_strobe_t [NUM_CPU-1:0]  strobes,
  output logic [NUM_CPU*PRIO_W-1:0]   bestPrio,
  output logic [NUM_CPU-1:0]          bestGrp,
  output logic [NUM_CPU-1:0]          bestHit,
  output logic [NUM_CPU-1:0]          irqOut,
  output logic [NUM_CPU-1:0]          fiqOut,
  output logic [NUM_CPU*ID_W-1:0]     curPendId
);

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
    logic [PRIO_W-1:0] winPrio;
    logic [ID_W-1:0]   winId;
    logic              winGrp;
    logic              winHit;

    // Linear scan; strict compare keeps the lowest ID on equal priority.
    always_comb begin
      winPrio = '1;
      winId   = SPURIOUS_ID;
      winGrp  = 1'b0;
      winHit  = 1'b0;
      for (int i = 0; i < NUM_IRQ; i++) begin
        if (pendVec[i] && enVec[i] && tgtVec[i*NUM_CPU+c] &&
            (!winHit || prioVec[i*PRIO_W +: PRIO_W] < winPrio)) begin
          winHit  = 1'b1;
          winPrio = prioVec[i*PRIO_W +: PRIO_W];
          winId   = ID_W'(i);
          winGrp  = grpVec[i];
        end
      end
    end

    assign bestPrio[c*PRIO_W +: PRIO_W] = winPrio;
    assign bestGrp[c] = winGrp;
    assign bestHit[c] = winHit;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        irqOut[c]                   <= 1'b0;
        fiqOut[c]                   <= 1'b0;
        curPendId[c*ID_W +: ID_W]   <= SPURIOUS_ID;
      end else begin
        irqOut[c]                   <= strobes[c].driveIrq;
        fiqOut[c]                   <= strobes[c].driveFiq;
        curPendId[c*ID_W +: ID_W]   <= strobes[c].latchId ? winId : SPURIOUS_ID;
      end
    end
  end

endmodule

// File: rtl/pendsel_ctrl.sv
module pendsel_ctrl
  import pendsel_pkg::*;
#(
  parameter int NUM_CPU = 2,
  parameter int PRIO_W  = 8,
  parameter int REV_W   = 4
) (
  input  logic                          distGrp0En,
  input  logic                          fiqSigEn,
  input  logic [REV_W-1:0]              revision,
  input  logic [NUM_CPU-1:0]            cpuEn,
  input  logic [NUM_CPU*(PRIO_W+1)-1:0] prioMask,
  input  logic [NUM_CPU*(PRIO_W+1)-1:0] runPrio,
  input  logic [NUM_CPU*PRIO_W-1:0]     bestPrio,
  input  logic [NUM_CPU-1:0]            bestGrp,
  input  logic [NUM_CPU-1:0]            bestHit,
  output pend_strobe_t [NUM_CPU-1:0]    strobes
);
  localparam int MW = PRIO_W + 1;

  logic steerAllowed;
  assign steerAllowed = fiqSigEn && (int'(revision) >= FIQ_MIN_REV);

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
    logic [MW-1:0] candPrio;
    logic gateOpen, passMask, passRun, toFiq;

    assign candPrio = {1'b0, bestPrio[c*PRIO_W +: PRIO_W]};
    assign gateOpen = distGrp0En && cpuEn[c];
    assign passMask = gateOpen && bestHit[c] && (candPrio < prioMask[c*MW +: MW]);
    assign passRun  = passMask && (candPrio < runPrio[c*MW +: MW]);
    assign toFiq    = steerAllowed && !bestGrp[c];

    assign strobes[c].latchId  = passMask;
    assign strobes[c].driveIrq = passRun && !toFiq;
    assign strobes[c].driveFiq = passRun && toFiq;
  end

endmodule

// File: rtl/pendsel_top.sv
module pendsel_top
  import pendsel_pkg::*;
#(
  parameter int NUM_IRQ = 64,
  parameter int NUM_CPU = 2,
  parameter int PRIO_W  = 8,
  parameter int REV_W   = 4
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [NUM_IRQ-1:0]            pendVec,
  input  logic [NUM_IRQ-1:0]            enVec,
  input  logic [NUM_IRQ-1:0]            grpVec,
  input  logic [NUM_IRQ*NUM_CPU-1:0]    tgtVec,
  input  logic [NUM_IRQ*PRIO_W-1:0]     prioVec,
  input  logic                          distGrp0En,
  input  logic                          fiqSigEn,
  input  logic [REV_W-1:0]              revision,
  input  logic [NUM_CPU-1:0]            cpuEn,
  input  logic [NUM_CPU*(PRIO_W+1)-1:0] prioMask,
  input  logic [NUM_CPU*(PRIO_W+1)-1:0] runPrio,
  output logic [NUM_CPU-1:0]            irqOut,
  output logic [NUM_CPU-1:0]            fiqOut,
  output logic [NUM_CPU*10-1:0]         curPendId
);

  pend_strobe_t [NUM_CPU-1:0]  strobes;
  logic [NUM_CPU*PRIO_W-1:0]   bestPrio;
  logic [NUM_CPU-1:0]          bestGrp;
  logic [NUM_CPU-1:0]          bestHit;

  pendsel_datapath #(.NUM_IRQ(NUM_IRQ), .NUM_CPU(NUM_CPU), .PRIO_W(PRIO_W)) u_dp (
    .clk(clk), .rstN(rstN),
    .pendVec(pendVec), .enVec(enVec), .grpVec(grpVec),
    .tgtVec(tgtVec), .prioVec(prioVec), .strobes(strobes),
    .bestPrio(bestPrio), .bestGrp(bestGrp), .bestHit(bestHit),
    .irqOut(irqOut), .fiqOut(fiqOut), .curPendId(curPendId)
  );

  pendsel_ctrl #(.NUM_CPU(NUM_CPU), .PRIO_W(PRIO_W), .REV_W(REV_W)) u_ctrl (
    .distGrp0En(distGrp0En), .fiqSigEn(fiqSigEn), .revision(revision),
    .cpuEn(cpuEn), .prioMask(prioMask), .runPrio(runPrio),
    .bestPrio(bestPrio), .bestGrp(bestGrp), .bestHit(bestHit),
    .strobes(strobes)
  );

endmodule

// File: rtl/pendsel_chk.sv
module pendsel_chk #(
  parameter int NUM_IRQ = 64,
  parameter int NUM_CPU = 2,
  parameter int PRIO_W  = 8,
  parameter int REV_W   = 4
) (
  input logic                          clk,
  input logic                          rstN,
  input logic [NUM_IRQ-1:0]            grpVec,
  input logic                          distGrp0En,
  input logic                          fiqSigEn,
  input logic [REV_W-1:0]              revision,
  input logic [NUM_CPU-1:0]            cpuEn,
  input logic [NUM_CPU*(PRIO_W+1)-1:0] prioMask,
  input logic [NUM_CPU*(PRIO_W+1)-1:0] runPrio,
  input logic [NUM_CPU-1:0]            irqOut,
  input logic [NUM_CPU-1:0]            fiqOut,
  input logic [NUM_CPU*10-1:0]         curPendId
);
  localparam int MW = PRIO_W + 1;

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
    p_gate_off_r6: assert property (@(posedge clk) disable iff (!rstN)
      !(distGrp0En && cpuEn[c]) |=>
        (!irqOut[c] && !fiqOut[c] && curPendId[c*10 +: 10] == 10'd1023));

    p_line_has_id_r4: assert property (@(posedge clk) disable iff (!rstN)
      (irqOut[c] || fiqOut[c]) |-> (curPendId[c*10 +: 10] != 10'd1023));

    p_closed_mask_r4: assert property (@(posedge clk) disable iff (!rstN)
      (prioMask[c*MW +: MW] == '0) |=> (curPendId[c*10 +: 10] == 10'd1023));

    p_busy_run_r5: assert property (@(posedge clk) disable iff (!rstN)
      (runPrio[c*MW +: MW] == '0) |=> (!irqOut[c] && !fiqOut[c]));

    p_no_fiq_r9: assert property (@(posedge clk) disable iff (!rstN)
      (!fiqSigEn || int'(revision) < 2) |=> !fiqOut[c]);

    p_grp1_irq_r8: assert property (@(posedge clk) disable iff (!rstN)
      (&grpVec) |=> !fiqOut[c]);

    p_one_line_r7: assert property (@(posedge clk) disable iff (!rstN)
      $countones({irqOut[c], fiqOut[c]}) <= 1);
  end

endmodule

bind pendsel_top pendsel_chk #(
  .NUM_IRQ(NUM_IRQ), .NUM_CPU(NUM_CPU), .PRIO_W(PRIO_W), .REV_W(REV_W)
) u_chk (.*);

// File: tb/sim_pendsel_top.sv
module sim_pendsel_top;
  localparam int NI = 8;
  localparam int NC = 2;
  localparam int PW = 8;
  localparam int RW = 4;
  localparam int NV = 13;

  typedef struct packed {
    logic [23:0] tag;
    logic [7:0]  pend, en, grp, tgt0, tgt1;
    logic        distEn, fiqEn;
    logic [3:0]  rev;
    logic [1:0]  cpuE;
    logic [1:0]  psel;
    logic [8:0]  mask0, mask1, run0, run1;
    logic [1:0]  expIrq, expFiq;
    logic [9:0]  expId0, expId1;
  } vec_t;

  // psel 0: prio = 16*(8-i); psel 1: all 0x40; psel 2: prio = 16*(i+1)
  localparam vec_t VECS [NV] = '{
    '{"R2 ", 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'h00, 1'b1, 1'b0, 4'd2, 2'b11, 2'd0,
      9'd256, 9'd256, 9'd256, 9'd256, 2'b01, 2'b00, 10'd7, 10'd1023},
    '{"R3 ", 8'hFF, 8'h7F, 8'hFF, 8'hFF, 8'hFF, 1'b1, 1'b0, 4'd2, 2'b11, 2'd0,
      9'd256, 9'd256, 9'd256, 9'd256, 2'b11, 2'b00, 10'd6, 10'd6},
    '{"R12", 8'h0C, 8'hFF, 8'hFF, 8'hFF, 8'h08, 1'b1, 1'b0, 4'd2, 2'b11, 2'd1,
      9'd256, 9'd256, 9'd256, 9'd256, 2'b11, 2'b00, 10'd2, 10'd3},
    '{"R7 ", 8'h03, 8'hFF, 8'hFE, 8'h01, 8'h02, 1'b1, 1'b1, 4'd2, 2'b11, 2'd2,
      9'd256, 9'd256, 9'd256, 9'd256, 2'b10, 2'b01, 10'd0, 10'd1},
    '{"R9 ", 8'h03, 8'hFF, 8'hFE, 8'h01, 8'h02, 1'b1, 1'b1, 4'd1, 2'b11, 2'd2,
      9'd256, 9'd256, 9'd256, 9'd256, 2'b11, 2'b00, 10'd0, 10'd1},
    '{"R8 ", 8'h03, 8'hFF, 8'hFE, 8'h01, 8'h02, 1'b1, 1'b0, 4'd2, 2'b11, 2'd2,
      9'd256, 9'd256, 9'd256, 9'd256, 2'b11, 2'b00, 10'd0, 10'd1},
    '{"R4 ", 8'h01, 8'h01, 8'hFF, 8'h01, 8'h01, 1'b1, 1'b0, 4'd2, 2'b11, 2'd2,
      9'd16, 9'd17, 9'd256, 9'd256, 2'b10, 2'b00, 10'd1023, 10'd0},
    '{"R5 ", 8'h01, 8'h01, 8'hFF, 8'h01, 8'h01, 1'b1, 1'b0, 4'd2, 2'b11, 2'd2,
      9'd256, 9'd256, 9'd16, 9'd17, 2'b10, 2'b00, 10'd0, 10'd0},
    '{"R10", 8'hFF, 8'h7F, 8'hFF, 8'hFF, 8'hFF, 1'b1, 1'b0, 4'd2, 2'b01, 2'd0,
      9'd256, 9'd256, 9'd256, 9'd256, 2'b01, 2'b00, 10'd6, 10'd1023},
    '{"R6 ", 8'hFF, 8'h7F, 8'hFF, 8'hFF, 8'hFF, 1'b0, 1'b0, 4'd2, 2'b11, 2'd0,
      9'd256, 9'd256, 9'd256, 9'd256, 2'b00, 2'b00, 10'd1023, 10'd1023},
    '{"R2 ", 8'hFF, 8'hFF, 8'hFF, 8'h00, 8'h00, 1'b1, 1'b0, 4'd2, 2'b11, 2'd0,
      9'd256, 9'd256, 9'd256, 9'd256, 2'b00, 2'b00, 10'd1023, 10'd1023},
    '{"R7 ", 8'h03, 8'hFF, 8'hFE, 8'h01, 8'h02, 1'b1, 1'b1, 4'd3, 2'b11, 2'd2,
      9'd256, 9'd256, 9'd256, 9'd256, 2'b10, 2'b01, 10'd0, 10'd1},
    '{"R5 ", 8'h03, 8'hFF, 8'hFE, 8'h01, 8'h02, 1'b1, 1'b1, 4'd2, 2'b11, 2'd2,
      9'd256, 9'd256, 9'd16, 9'd256, 2'b10, 2'b00, 10'd0, 10'd1}
  };

  logic                  clk = 1'b0;
  logic                  rstN = 1'b0;
  logic [NI-1:0]         pendVec, enVec, grpVec;
  logic [NI*NC-1:0]      tgtVec;
  logic [NI*PW-1:0]      prioVec;
  logic                  distGrp0En, fiqSigEn;
  logic [RW-1:0]         revision;
  logic [NC-1:0]         cpuEn;
  logic [NC*(PW+1)-1:0]  prioMask, runPrio;
  logic [NC-1:0]         irqOut, fiqOut;
  logic [NC*10-1:0]      curPendId;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pendsel_top #(.NUM_IRQ(NI), .NUM_CPU(NC), .PRIO_W(PW), .REV_W(RW)) u0 (
    .clk(clk), .rstN(rstN), .pendVec(pendVec), .enVec(enVec), .grpVec(grpVec),
    .tgtVec(tgtVec), .prioVec(prioVec), .distGrp0En(distGrp0En),
    .fiqSigEn(fiqSigEn), .revision(revision), .cpuEn(cpuEn),
    .prioMask(prioMask), .runPrio(runPrio), .irqOut(irqOut),
    .fiqOut(fiqOut), .curPendId(curPendId)
  );

  function automatic logic [NI*PW-1:0] prioPattern(input logic [1:0] sel);
    logic [NI*PW-1:0] p;
    for (int i = 0; i < NI; i++) begin
      case (sel)
        2'd0:    p[i*PW +: PW] = PW'(16 * (8 - i));
        2'd1:    p[i*PW +: PW] = 8'h40;
        default: p[i*PW +: PW] = PW'(16 * (i + 1));
      endcase
    end
    return p;
  endfunction

  task automatic drive(input vec_t v);
    pendVec    = v.pend;
    enVec      = v.en;
    grpVec     = v.grp;
    for (int i = 0; i < NI; i++) begin
      tgtVec[i*NC]   = v.tgt0[i];
      tgtVec[i*NC+1] = v.tgt1[i];
    end
    prioVec    = prioPattern(v.psel);
    distGrp0En = v.distEn;
    fiqSigEn   = v.fiqEn;
    revision   = v.rev;
    cpuEn      = v.cpuE;
    prioMask   = {v.mask1, v.mask0};
    runPrio    = {v.run1, v.run0};
  endtask

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic checkAll(input string req, input int eIrq, input int eFiq,
                          input int eId0, input int eId1);
    check(req, "irqOut", int'(irqOut), eIrq);
    check(req, "fiqOut", int'(fiqOut), eFiq);
    check(req, "id cpu0", int'(curPendId[9:0]), eId0);
    check(req, "id cpu1", int'(curPendId[19:10]), eId1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R11 watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: stimulus that would raise lines is present during reset
    drive(VECS[0]);
    repeat (3) @(negedge clk);
    checkAll("R1", 0, 0, 1023, 1023);
    rstN = 1'b1;

    // Table walk: drive on falling edge, sample at the next falling edge
    for (int k = 0; k < NV; k++) begin
      @(negedge clk);
      drive(VECS[k]);
      @(negedge clk);
      checkAll(string'(VECS[k].tag), int'(VECS[k].expIrq), int'(VECS[k].expFiq),
               int'(VECS[k].expId0), int'(VECS[k].expId1));
    end

    // R11: outputs change only at the rising edge after the inputs change
    @(negedge clk);
    drive(VECS[9]);
    @(negedge clk);
    drive(VECS[0]);
    #1;
    checkAll("R11", 0, 0, 1023, 1023);
    @(negedge clk);
    checkAll("R11", 1, 0, 7, 1023);

    // R1: reset taken mid-run clears everything at once
    rstN = 1'b0;
    #1;
    checkAll("R1", 0, 0, 1023, 1023);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checkAll("R2", 1, 0, 7, 1023);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule